// File: doc/BRIEF.md
# Clock Source Control Register with Hardware Overrides

This block is the control and status word of a clock controller that manages three oscillators and one PLL. The oscillators are a multi-speed internal oscillator (MS), a 16 MHz internal oscillator (HI) and an external crystal (XT). Software writes the whole 32-bit word in one cycle and reads it back at any time. Each oscillator and the PLL has an enable bit, and the block drives one enable output per source from these bits.

The block does not store software writes as they come. Low-power entry clears all the enables. Wake-up events and a crystal failure force some enables on. A source that feeds the system clock cannot be switched off. Some bits can only be set, and some fields accept a write only in certain states. The ready flags follow modelled stability inputs. After a source is disabled, its flag stays high until a fixed number of ticks of that source's own clock have gone by. The block also chooses the active multi-speed range, and it drives the enable for the crystal failure detector.

The analog oscillators, the PLL lock detector and the failure detector are outside the block. Each one is represented by an input: a stability level, a lock level, a source-clock tick pulse, or a failure pulse.

Top module: `clkctl_reg`

## Requirements
- R1: After reset the word reads 32'h0060_0000. Every bit is 0 except the 4-bit range field at bits 23:20, which holds 6. All enable outputs and the detector enable are 0.
- R2: A `lp_enter` pulse clears four enable bits at the next clock edge, whatever else happens in that cycle: XT bit 0, PLL bit 4, HI bit 8 and MS bit 16. The block is then in stop until an exit pulse. While in stop with the keep bit (bit 10) set, `hi_osc_en` stays 1 even though the HI enable bit is 0.
- R3: A `lp_exit_deep` pulse sets the MS enable. A `lp_exit_stop` pulse with `wake_sel`=0 sets the MS enable. If the auto-start bit (bit 11) is also set, that pulse sets the HI enable as well. A `lp_exit_stop` pulse with `wake_sel`=1 sets only the HI enable. An `xt_fail` pulse sets the MS enable.
- R4: A software write of 0 cannot clear the enable of a source that is in use. System source codes are 0=MS, 1=HI, 2=XT and 3=PLL. PLL reference codes are 0=MS, 1=HI, 2=XT and 3=none. A source is in use when it is the system source, or when the system source is the PLL and the source is the PLL reference.
- R5: A ready flag is set one cycle after its enable bit is 1 with its stable input high. Ready flags sit at MS bit 17, HI bit 9 and XT bit 1. A flag never sets while its enable bit is 0. After the enable is cleared, the flag falls at the clock edge that samples the 6th source tick.
- R6: The PLL ready flag (bit 5) equals `pll_lock` delayed by one cycle.
- R7: The range-select bit (bit 19) is set-only and resets to 0. `ms_range_act` shows `stby_range` while this bit is 0 and shows the range field while it is 1.
- R8: A write to the range field takes effect only if the value is 11 or less. It is also ignored while the MS enable is 1 and the MS ready flag is 0.
- R9: The MS lock-mode bit (bit 18) can be written to 1 only when `lsx_on` and `lsx_rdy` are both 1. Hardware clears it when `lsx_on` is 0 or `lsx_fail` is 1, and this takes priority over a write.
- R10: The bypass bit (bit 2) changes on a write only if the XT enable bit was 0 before the write.
- R11: The supervisor bit (bit 3) is set-only and is cleared only by reset. `mon_en` is 1 exactly when this bit is set, the XT ready flag is 1, and no `xt_fail` pulse has occurred since reset.
- R12: Writes to the ready flags (bits 1, 5, 9 and 17) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| lp_enter | input | 1 | Low-power entry pulse |
| lp_exit_stop | input | 1 | Exit-from-stop pulse |
| lp_exit_deep | input | 1 | Exit-from-standby/shutdown pulse |
| wake_sel | input | 1 | Stop wake-up clock: 0 = MS, 1 = HI |
| sys_src | input | 2 | System clock source code |
| pll_ref | input | 2 | PLL reference source code |
| xt_fail | input | 1 | Crystal failure pulse from detector |
| lsx_on | input | 1 | Low-speed crystal enabled |
| lsx_rdy | input | 1 | Low-speed crystal ready |
| lsx_fail | input | 1 | Low-speed crystal failure |
| ms_stable | input | 1 | MS oscillator stable |
| hi_stable | input | 1 | HI oscillator stable |
| xt_stable | input | 1 | XT oscillator stable |
| pll_lock | input | 1 | PLL lock level |
| ms_tick | input | 1 | One pulse per MS source clock edge |
| hi_tick | input | 1 | One pulse per HI source clock edge |
| xt_tick | input | 1 | One pulse per XT source clock edge |
| stby_range | input | 4 | Range used while range-select is 0 |
| ms_osc_en | output | 1 | MS oscillator enable |
| hi_osc_en | output | 1 | HI oscillator enable |
| xt_osc_en | output | 1 | XT oscillator enable |
| pll_osc_en | output | 1 | PLL enable |
| mon_en | output | 1 | Crystal failure detector enable |
| ms_range_act | output | 4 | Active MS range |

## Verification
The bench writes all sixteen range values, both with the oscillator idle and during MS start-up. A block that compared against the wrong limit, or ignored the start-up guard, would show a bad value in the range field. It sweeps every pairing of system source and PLL reference. In each pairing it tries to clear all four enables, which exposes a block that misses the indirect use through the PLL reference or protects the wrong source. The ready-drop check counts slow ticks one at a time, so a counter that is off by one gives a flag that falls on the 5th or 7th tick. The set-only bits, the locked bypass and lock-mode bits, the wake-up forcing and the stop keep-alive path are each driven with the input that a faulty block would wrongly obey.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W = 32;
  localparam int RNG_W = 4;

  localparam int B_XT_EN   = 0;
  localparam int B_XT_RDY  = 1;
  localparam int B_XT_BYP  = 2;
  localparam int B_SUP     = 3;
  localparam int B_PLL_EN  = 4;
  localparam int B_PLL_RDY = 5;
  localparam int B_HI_EN   = 8;
  localparam int B_HI_RDY  = 9;
  localparam int B_HI_KEEP = 10;
  localparam int B_HI_AUTO = 11;
  localparam int B_MS_EN   = 16;
  localparam int B_MS_RDY  = 17;
  localparam int B_MS_LOCK = 18;
  localparam int B_MS_RSEL = 19;
  localparam int B_RNG_LO  = 20;

  localparam logic [RNG_W-1:0] RANGE_MAX = 4'd11;
  localparam logic [RNG_W-1:0] RANGE_RST = 4'd6;

  // source index order used for all per-source arrays
  typedef enum logic [1:0] {SRC_MS = 2'd0, SRC_HI = 2'd1, SRC_XT = 2'd2, SRC_PLL = 2'd3} src_e;
  localparam int N_SRC = 4;
  localparam int N_OSC = 3;

  function automatic int en_pos(input int idx);
    case (idx)
      0: return B_MS_EN;
      1: return B_HI_EN;
      2: return B_XT_EN;
      default: return B_PLL_EN;
    endcase
  endfunction

  function automatic logic range_ok(input logic [RNG_W-1:0] v);
    return v <= RANGE_MAX;
  endfunction

  // a source is busy if it drives the system clock or feeds the PLL that does
  function automatic logic src_busy(input int idx, input logic [1:0] sys, input logic [1:0] pref);
    logic direct, via_pll;
    direct  = (sys == 2'(idx));
    via_pll = (idx < 3) && (sys == 2'(SRC_PLL)) && (pref == 2'(idx));
    return direct || via_pll;
  endfunction

  function automatic logic [RNG_W-1:0] pick_range(input logic sel,
                                                  input logic [RNG_W-1:0] sw_rng,
                                                  input logic [RNG_W-1:0] sb_rng);
    return sel ? sw_rng : sb_rng;
  endfunction
endpackage

// File: rtl/clkctl_en_bit.sv
module clkctl_en_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_clear,
  input  logic hw_set,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic in_use,
  output logic en_q
);
  logic sw_next;
  // a busy source keeps its enable when software writes 0
  assign sw_next = wr_bit | (in_use & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (hw_clear) en_q <= 1'b0;
    else if (hw_set)   en_q <= 1'b1;
    else if (wr_en)    en_q <= sw_next;
  end
endmodule

// File: rtl/clkctl_rdy_track.sv
module clkctl_rdy_track #(
  parameter int DROP_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stable,
  input  logic tick,
  output logic rdy_q
);
  localparam int CW = $clog2(DROP_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DROP_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          draining;
  logic          drop_now;

  assign draining = !en && rdy_q;
  assign drop_now = draining && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      rdy_q <= stable;
      cnt_q <= '0;
    end else if (drop_now) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (draining && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_ms_cfg.sv
module clkctl_ms_cfg
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_rsel,
  input  logic             wr_lock,
  input  logic [RNG_W-1:0] wr_range,
  input  logic             ms_en,
  input  logic             ms_rdy,
  input  logic             lsx_on,
  input  logic             lsx_rdy,
  input  logic             lsx_fail,
  input  logic [RNG_W-1:0] stby_range,
  output logic             rsel_q,
  output logic             lock_q,
  output logic [RNG_W-1:0] range_q,
  output logic [RNG_W-1:0] range_act
);
  logic starting;
  logic range_take;
  logic lock_kill;
  logic lock_ok;

  assign starting   = ms_en && !ms_rdy;
  assign range_take = wr_en && range_ok(wr_range) && !starting;
  assign lock_kill  = !lsx_on || lsx_fail;
  assign lock_ok    = lsx_on && lsx_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= 1'b0;
      lock_q  <= 1'b0;
      range_q <= RANGE_RST;
    end else begin
      if (wr_en && wr_rsel) rsel_q <= 1'b1;
      if (range_take) range_q <= wr_range;
      if (lock_kill)                 lock_q <= 1'b0;
      else if (wr_en && !wr_lock)    lock_q <= 1'b0;
      else if (wr_en && lock_ok)     lock_q <= 1'b1;
    end
  end

  assign range_act = pick_range(rsel_q, range_q, stby_range);
endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
#(
  parameter int DROP_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             lp_enter,
  input  logic             lp_exit_stop,
  input  logic             lp_exit_deep,
  input  logic             wake_sel,
  input  logic [1:0]       sys_src,
  input  logic [1:0]       pll_ref,
  input  logic             xt_fail,
  input  logic             lsx_on,
  input  logic             lsx_rdy,
  input  logic             lsx_fail,
  input  logic             ms_stable,
  input  logic             hi_stable,
  input  logic             xt_stable,
  input  logic             pll_lock,
  input  logic             ms_tick,
  input  logic             hi_tick,
  input  logic             xt_tick,
  input  logic [RNG_W-1:0] stby_range,
  output logic             ms_osc_en,
  output logic             hi_osc_en,
  output logic             xt_osc_en,
  output logic             pll_osc_en,
  output logic             mon_en,
  output logic [RNG_W-1:0] ms_range_act
);
  // named events, also observed by the bound checker
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] src_used;
  logic [N_SRC-1:0] hw_set;
  logic [N_OSC-1:0] osc_stable;
  logic [N_OSC-1:0] osc_tick;
  logic [N_OSC-1:0] rdy_q;
  logic             stop_q;
  logic             byp_q;
  logic             sup_q;
  logic             keep_q;
  logic             auto_q;
  logic             fail_seen_q;
  logic             pll_rdy_q;
  logic             rsel_q;
  logic             lock_q;
  logic [RNG_W-1:0] range_q;
  logic             byp_take;
  logic             wake_ms;
  logic             wake_hi;
  logic             unused_wr;

  assign wake_ms = lp_exit_deep || (lp_exit_stop && !wake_sel) || xt_fail;
  assign wake_hi = lp_exit_stop && (wake_sel || auto_q);
  assign hw_set  = {1'b0, 1'b0, wake_hi, wake_ms};

  assign osc_stable = {xt_stable, hi_stable, ms_stable};
  assign osc_tick   = {xt_tick, hi_tick, ms_tick};

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_en
      localparam int POS = en_pos(i);
      assign src_used[i] = src_busy(i, sys_src, pll_ref);
      clkctl_en_bit u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_clear (lp_enter),
        .hw_set   (hw_set[i]),
        .wr_en    (wr_en),
        .wr_bit   (wr_data[POS]),
        .in_use   (src_used[i]),
        .en_q     (en_q[i])
      );
    end
    for (genvar k = 0; k < N_OSC; k++) begin : g_rdy
      clkctl_rdy_track #(.DROP_TICKS(DROP_TICKS)) u_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q[k]),
        .stable (osc_stable[k]),
        .tick   (osc_tick[k]),
        .rdy_q  (rdy_q[k])
      );
    end
  endgenerate

  clkctl_ms_cfg u_ms (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_rsel    (wr_data[B_MS_RSEL]),
    .wr_lock    (wr_data[B_MS_LOCK]),
    .wr_range   (wr_data[B_RNG_LO +: RNG_W]),
    .ms_en      (en_q[SRC_MS]),
    .ms_rdy     (rdy_q[SRC_MS]),
    .lsx_on     (lsx_on),
    .lsx_rdy    (lsx_rdy),
    .lsx_fail   (lsx_fail),
    .stby_range (stby_range),
    .rsel_q     (rsel_q),
    .lock_q     (lock_q),
    .range_q    (range_q),
    .range_act  (ms_range_act)
  );

  assign byp_take = wr_en && !en_q[SRC_XT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q      <= 1'b0;
      byp_q       <= 1'b0;
      sup_q       <= 1'b0;
      keep_q      <= 1'b0;
      auto_q      <= 1'b0;
      fail_seen_q <= 1'b0;
      pll_rdy_q   <= 1'b0;
    end else begin
      if (lp_enter)                          stop_q <= 1'b1;
      else if (lp_exit_stop || lp_exit_deep) stop_q <= 1'b0;
      if (byp_take) byp_q <= wr_data[B_XT_BYP];
      if (wr_en && wr_data[B_SUP]) sup_q <= 1'b1;
      if (wr_en) begin
        keep_q <= wr_data[B_HI_KEEP];
        auto_q <= wr_data[B_HI_AUTO];
      end
      if (xt_fail) fail_seen_q <= 1'b1;
      pll_rdy_q <= pll_lock;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[B_XT_EN]              = en_q[SRC_XT];
    rd_data[B_XT_RDY]             = rdy_q[SRC_XT];
    rd_data[B_XT_BYP]             = byp_q;
    rd_data[B_SUP]                = sup_q;
    rd_data[B_PLL_EN]             = en_q[SRC_PLL];
    rd_data[B_PLL_RDY]            = pll_rdy_q;
    rd_data[B_HI_EN]              = en_q[SRC_HI];
    rd_data[B_HI_RDY]             = rdy_q[SRC_HI];
    rd_data[B_HI_KEEP]            = keep_q;
    rd_data[B_HI_AUTO]            = auto_q;
    rd_data[B_MS_EN]              = en_q[SRC_MS];
    rd_data[B_MS_RDY]             = rdy_q[SRC_MS];
    rd_data[B_MS_LOCK]            = lock_q;
    rd_data[B_MS_RSEL]            = rsel_q;
    rd_data[B_RNG_LO +: RNG_W]    = range_q;
  end

  assign unused_wr = ^{wr_data[31:24], wr_data[15:12], wr_data[7:6],
                       wr_data[B_XT_RDY], wr_data[B_PLL_RDY], wr_data[B_HI_RDY], wr_data[B_MS_RDY]};

  assign ms_osc_en  = en_q[SRC_MS];
  assign hi_osc_en  = en_q[SRC_HI] || (keep_q && stop_q);
  assign xt_osc_en  = en_q[SRC_XT];
  assign pll_osc_en = en_q[SRC_PLL];
  assign mon_en     = sup_q && rdy_q[SRC_XT] && !fail_seen_q;
endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_enter,
  input logic       lsx_on,
  input logic       lsx_fail,
  input logic [3:0] en_q,
  input logic [3:0] src_used,
  input logic [2:0] rdy_q,
  input logic       sup_q,
  input logic       rsel_q,
  input logic       lock_q,
  input logic [3:0] range_q,
  input logic       mon_en
);
  assert_lp_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |=> (en_q == 4'b0000));

  assert_ms_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used[0] && en_q[0] && !lp_enter) |=> en_q[0]);
  assert_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used[1] && en_q[1] && !lp_enter) |=> en_q[1]);
  assert_xt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used[2] && en_q[2] && !lp_enter) |=> en_q[2]);
  assert_pll_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_used[3] && en_q[3] && !lp_enter) |=> en_q[3]);

  assert_hi_rdy_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q[1]) |-> $past(en_q[1]));

  assert_rsel_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsel_q |=> rsel_q);

  assert_range_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    range_q <= 4'd11);

  assert_lock_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsx_on || lsx_fail) |=> !lock_q);

  assert_sup_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sup_q |=> sup_q);

  assert_mon_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> (sup_q && rdy_q[2]));
endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lp_enter (lp_enter),
  .lsx_on   (lsx_on),
  .lsx_fail (lsx_fail),
  .en_q     (en_q),
  .src_used (src_used),
  .rdy_q    (rdy_q),
  .sup_q    (sup_q),
  .rsel_q   (rsel_q),
  .lock_q   (lock_q),
  .range_q  (range_q),
  .mon_en   (mon_en)
);

// File: tb/clkctl_reg_test.sv
`timescale 1ns/1ps
module clkctl_reg_test;
  localparam int XE = 0, XR = 1, XB = 2, SUP = 3, PE = 4, PR = 5;
  localparam int HE = 8, HR = 9, HK = 10, HA = 11;
  localparam int ME = 16, MR = 17, ML = 18, MS = 19, RL = 20;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic lp_enter = 0, lp_exit_stop = 0, lp_exit_deep = 0, wake_sel = 0;
  logic [1:0] sys_src = 2'd2, pll_ref = 2'd3;
  logic xt_fail = 0, lsx_on = 0, lsx_rdy = 0, lsx_fail = 0;
  logic ms_stable = 0, hi_stable = 0, xt_stable = 0, pll_lock = 0;
  logic ms_tick = 0, hi_tick = 0, xt_tick = 0;
  logic [3:0] stby_range = 4'd3;
  logic ms_osc_en, hi_osc_en, xt_osc_en, pll_osc_en, mon_en;
  logic [3:0] ms_range_act;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] sw = '0;
  logic [3:0] exp_rng;
  logic [31:0] snap;

  always #2 clk = ~clk;

  clkctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lp_enter(lp_enter), .lp_exit_stop(lp_exit_stop), .lp_exit_deep(lp_exit_deep),
    .wake_sel(wake_sel), .sys_src(sys_src), .pll_ref(pll_ref), .xt_fail(xt_fail),
    .lsx_on(lsx_on), .lsx_rdy(lsx_rdy), .lsx_fail(lsx_fail),
    .ms_stable(ms_stable), .hi_stable(hi_stable), .xt_stable(xt_stable), .pll_lock(pll_lock),
    .ms_tick(ms_tick), .hi_tick(hi_tick), .xt_tick(xt_tick), .stby_range(stby_range),
    .ms_osc_en(ms_osc_en), .hi_osc_en(hi_osc_en), .xt_osc_en(xt_osc_en),
    .pll_osc_en(pll_osc_en), .mon_en(mon_en), .ms_range_act(ms_range_act));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, register at the rising edge, return at the next falling edge
  task automatic wr(input logic [31:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  function automatic logic busy(input int k, input int s, input int r);
    if (k == 3) return s == 3;
    return (s == k) || (s == 3 && r == k);
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word", rd_data, 32'h0060_0000);
    chk("R1 outs", {27'd0, ms_osc_en, hi_osc_en, xt_osc_en, pll_osc_en, mon_en}, 32'd0);
    chk("R1 act", {28'd0, ms_range_act}, 32'd3);
    sw[RL +: 4] = 4'd6;

    // R8 sweep with MS idle, R7 mux shows standby range
    exp_rng = 4'd6;
    for (int v = 0; v < 16; v++) begin
      sw[RL +: 4] = 4'(v);
      wr(sw);
      if (v < 12) exp_rng = 4'(v);
      sw[RL +: 4] = exp_rng;
      chk($sformatf("R8 range v=%0d", v), {28'd0, rd_data[RL +: 4]}, {28'd0, exp_rng});
      chk("R7 act stby", {28'd0, ms_range_act}, 32'd3);
    end

    // R7 set-only select
    sw[MS] = 1; wr(sw);
    chk("R7 sel set", {28'd0, ms_range_act}, 32'd11);
    sw[MS] = 0; wr(sw);
    chk("R7 sel sticky", {31'd0, rd_data[MS]}, 32'd1);
    stby_range = 4'd5; @(negedge clk);
    chk("R7 stby ignored", {28'd0, ms_range_act}, 32'd11);

    // R8 start-up guard
    sw[ME] = 1; wr(sw);
    chk("R5 ms not ready", {31'd0, rd_data[MR]}, 32'd0);
    sw[RL +: 4] = 4'd2; wr(sw);
    chk("R8 guard", {28'd0, rd_data[RL +: 4]}, 32'd11);
    ms_stable = 1; @(negedge clk);
    chk("R5 ms ready", {31'd0, rd_data[MR]}, 32'd1);
    wr(sw);
    chk("R8 after ready", {28'd0, ms_range_act}, 32'd2);

    // R5 six-tick drop
    sw[ME] = 0; wr(sw);
    chk("R5 hold after clear", {31'd0, rd_data[MR]}, 32'd1);
    for (int t = 1; t <= 6; t++) begin
      ms_tick = 1; @(negedge clk); ms_tick = 0;
      chk($sformatf("R5 drop tick %0d", t), {31'd0, rd_data[MR]}, (t < 6) ? 32'd1 : 32'd0);
      @(negedge clk); @(negedge clk);
    end

    // R5 HI flag needs its enable
    hi_stable = 1; @(negedge clk); @(negedge clk);
    chk("R5 hi off", {31'd0, rd_data[HR]}, 32'd0);
    sw[HE] = 1; wr(sw);
    chk("R5 hi same cycle", {31'd0, rd_data[HR]}, 32'd0);
    @(negedge clk);
    chk("R5 hi ready", {31'd0, rd_data[HR]}, 32'd1);

    // R6 lock mirror
    pll_lock = 1; @(negedge clk);
    chk("R6 lock high", {31'd0, rd_data[PR]}, 32'd1);
    pll_lock = 0; @(negedge clk);
    chk("R6 lock low", {31'd0, rd_data[PR]}, 32'd0);

    // R12 read-only flags
    snap = rd_data;
    wr(sw | 32'h0002_0222);
    chk("R12 ro bits", rd_data, snap);

    // R10 bypass write lock
    xt_stable = 1;
    sw[XB] = 1; wr(sw);
    chk("R10 byp set off", {31'd0, rd_data[XB]}, 32'd1);
    sw[XE] = 1; wr(sw);
    sw[XB] = 0; wr(sw);
    chk("R10 byp locked", {31'd0, rd_data[XB]}, 32'd1);
    sw[XB] = 1;

    // R11 supervisor and detector enable
    sw[SUP] = 1; wr(sw);
    chk("R11 mon on", {31'd0, mon_en}, 32'd1);
    sw[SUP] = 0; wr(sw);
    chk("R11 sup sticky", {31'd0, rd_data[SUP]}, 32'd1);
    pulse(xt_fail);
    chk("R11 mon after fail", {31'd0, mon_en}, 32'd0);
    chk("R3 fail forces ms", {31'd0, rd_data[ME]}, 32'd1);
    sw[ME] = 1; sw[SUP] = 1;

    // R9 lock-mode bit
    sw[ML] = 1; wr(sw);
    chk("R9 lsx off", {31'd0, rd_data[ML]}, 32'd0);
    lsx_on = 1; wr(sw);
    chk("R9 lsx not rdy", {31'd0, rd_data[ML]}, 32'd0);
    lsx_rdy = 1; wr(sw);
    chk("R9 allowed", {31'd0, rd_data[ML]}, 32'd1);
    pulse(lsx_fail);
    chk("R9 hw clear", {31'd0, rd_data[ML]}, 32'd0);
    sw[ML] = 0;

    // R4 protection sweep over every source/reference pairing
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        sys_src = 2'(s); pll_ref = 2'(r);
        sw[ME] = 1; sw[HE] = 1; sw[XE] = 1; sw[PE] = 1; wr(sw);
        sw[ME] = 0; sw[HE] = 0; sw[XE] = 0; sw[PE] = 0; wr(sw);
        chk($sformatf("R4 ms s=%0d r=%0d", s, r), {31'd0, rd_data[ME]}, {31'd0, busy(0, s, r)});
        chk($sformatf("R4 hi s=%0d r=%0d", s, r), {31'd0, rd_data[HE]}, {31'd0, busy(1, s, r)});
        chk($sformatf("R4 xt s=%0d r=%0d", s, r), {31'd0, rd_data[XE]}, {31'd0, busy(2, s, r)});
        chk($sformatf("R4 pll s=%0d r=%0d", s, r), {31'd0, rd_data[PE]}, {31'd0, busy(3, s, r)});
      end
    end

    // R2 entry clears, keep bit holds HI in stop
    sw[ME] = 1; sw[HE] = 1; sw[XE] = 1; sw[PE] = 1; sw[HK] = 1; wr(sw);
    pulse(lp_enter);
    chk("R2 enables cleared", rd_data & 32'h0001_0111, 32'd0);
    chk("R2 keep in stop", {31'd0, hi_osc_en}, 32'd1);
    chk("R2 xt out off", {31'd0, xt_osc_en}, 32'd0);
    wake_sel = 0; pulse(lp_exit_stop);
    chk("R3 stop exit ms", {30'd0, rd_data[ME], rd_data[HE]}, 32'd2);
    chk("R2 keep ends", {31'd0, hi_osc_en}, 32'd0);

    pulse(lp_enter);
    wake_sel = 1; pulse(lp_exit_stop);
    chk("R3 stop exit hi", {30'd0, rd_data[ME], rd_data[HE]}, 32'd1);

    sw[HA] = 1; wr(sw);
    pulse(lp_enter);
    wake_sel = 0; pulse(lp_exit_stop);
    chk("R3 auto start", {30'd0, rd_data[ME], rd_data[HE]}, 32'd3);

    pulse(lp_enter);
    pulse(lp_exit_deep);
    chk("R3 deep exit", {30'd0, rd_data[ME], rd_data[HE]}, 32'd2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule